// File: doc/BRIEF.md
# Prescaled Match Timer with Output Actions

This block is a free-running counter paced by a programmable prescaler. A prescale count climbs from zero up to a limit value and then wraps to zero. On each wrap, called a tick, the main counter advances by one. Four match channels compare the main counter with their own compare values, and they do this only on a tick. A channel that matches can do any mix of three things: set its interrupt flag, send the counter back to zero, or halt counting. Each channel also drives an output pin, and on a match the pin is left alone, forced low, forced high or inverted.

Software controls the block through a flat word-addressed write port with a combinational read path. Through it, software starts and holds the counters, sets the prescale limit and the compare values, picks the per-channel actions, presets the pin levels, reads and clears the interrupt flags, and loads either counter directly. The address map, in word units, is:

- 0: flags
- 1: control
- 2: main counter
- 3: prescale limit
- 4: prescale count
- 5: match actions
- 6 to 9: compare values of channels 0 to 3
- 10: pin control

Top module: `match_timer`

## Requirements
- R1: While counting is enabled and not held, the prescale count runs 0, 1, ..., limit and then wraps to 0. The main counter advances on the clock where the prescale count equals the limit, so after N clocks from zero the main counter reads N/(limit+1) (integer division) and the prescale count reads N mod (limit+1).
- R2: Control bit 0 enables counting. Control bit 1 holds both counters at zero. When bit 0 and bit 1 are both clear, both counters keep their values. Control reads back as bits [1:0] only.
- R3: A channel n matches on a tick when the main counter equals its compare value. If bit 3n+1 of the match-action register is set, that tick loads the main counter with 0 instead of incrementing it, so the counter cycles through compare+1 values.
- R4: If bit 3n+2 of the match-action register is set, a match clears control bit 0. Both counters then hold: the main counter stays at the compare value, or at 0 when the reset bit of R3 is also set, and the prescale count stays at 0.
- R5: If bit 3n of the match-action register is set, a match sets flag bit n (bits 0 to 3 at address 0). The irq output is the OR of all flags. Writing 1 to a flag bit clears it. Writing 0 leaves it as it is. A match wins over a clear in the same cycle. With bit 3n clear, a match leaves the flag at 0.
- R6: Pin control holds the pin levels in bits [3:0]. It holds the 2-bit action of channel n in bits [5+2n:4+2n]. The action codes are: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 inverts it. The action is applied on the tick of a match.
- R7: Writes to the main counter and to the prescale count take effect on the next clock edge, and reads return the stored value at once.
- R8: After reset, every register reads 0, all pins are low and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| match_out | output | N_CH | Match output pins |
| irq | output | 1 | OR of the interrupt flags |

## Verification
The embedded properties check the following on every cycle:
- the prescale count wraps to zero after each tick
- the hold bit zeroes both counters
- a disabled counter keeps its value
- a reset match returns the counter to zero
- a stop match clears the enable bit
- flags set on an enabled match and clear on a written one
- each pin action takes effect

The timing of whole sequences can only be shown by the bench's scenarios. These cover the N/(limit+1) count relation over a sweep of limits, the compare+1 period, where the counter rests after a stop, and every pin action from both starting levels. They also cover the set-beats-clear collision and the exact cycle in which each effect becomes visible.

// File: rtl/mtmr_pkg.sv
// Shared types for the prescaled match timer.
// Assumes: a word-addressed register port at most 16 words deep.
package mtmr_pkg;

    // Pin action applied when a channel matches.
    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_LOW  = 2'd1,
        ACT_HIGH = 2'd2,
        ACT_FLIP = 2'd3
    } ext_act_e;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
    localparam logic [ADDR_W-1:0] A_PLIM  = 4'd3;
    localparam logic [ADDR_W-1:0] A_PCNT  = 4'd4;
    localparam logic [ADDR_W-1:0] A_MACT  = 4'd5;
    localparam int unsigned       A_MR0   = 6;

endpackage

// File: rtl/mtmr_prescaler.sv
// Prescale counter: counts 0..limit and emits a one-cycle tick on the
// clock where it equals the limit, then wraps to zero.
// Assumes: hold has priority over a software write, and a write has
// priority over counting.
module mtmr_prescaler #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold,
    input  logic [W-1:0] limit,
    input  logic         pc_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pc,
    output logic         tick
);

    // Tick when running and the count has reached the limit.
    always_comb tick = run && (pc == limit);

    // Prescale count register: hold, load, wrap or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (hold) begin
            pc <= '0;
        end else if (pc_we) begin
            pc <= wdata;
        end else if (run) begin
            pc <= tick ? '0 : pc + 1'b1;
        end
    end

    // R1: after a tick the count restarts from zero
    assert_pc_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pc_we) |=> (pc == '0));

    // R2: hold forces the prescale count to zero
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pc == '0));

endmodule

// File: rtl/mtmr_match_chan.sv
// One match channel: stores a compare value, flags a hit on a tick when
// the counter equals it, and drives its output pin per the 2-bit action.
// Assumes: a software preset of the pin is applied first, and the match
// action then acts on that preset value.
module mtmr_match_chan #(
    parameter int unsigned W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [W-1:0]       tc,
    input  logic               mr_we,
    input  logic [W-1:0]       wdata,
    input  mtmr_pkg::ext_act_e act,
    input  logic               st_we,
    input  logic               st_wbit,
    output logic               hit,
    output logic [W-1:0]       mr,
    output logic               pin
);
    import mtmr_pkg::*;

    logic base;
    logic pin_d;

    // Match only on a prescaler tick.
    always_comb hit = tick && (tc == mr);

    // Next pin level: preset first, then the match action.
    always_comb begin
        base  = st_we ? st_wbit : pin;
        pin_d = base;
        if (hit) begin
            case (act)
                ACT_LOW:  pin_d = 1'b0;
                ACT_HIGH: pin_d = 1'b1;
                ACT_FLIP: pin_d = ~base;
                default:  pin_d = base;
            endcase
        end
    end

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)     mr <= '0;
        else if (mr_we) mr <= wdata;
    end

    // Pin state register.
    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_d;
    end

    // R6: action code 2 drives the pin high
    assert_pin_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_HIGH) |=> pin);

    // R6: action code 1 drives the pin low
    assert_pin_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_LOW) |=> !pin);

    // R6: action code 3 inverts the pin
    assert_pin_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_FLIP && !st_we) |=> (pin != $past(pin)));

    // R6: without a match or a preset the pin keeps its level
    assert_pin_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !st_we) |=> $stable(pin));

endmodule

// File: rtl/match_timer.sv
// Prescaled match timer: holds the control, counter, action and flag
// registers, instantiates the prescaler and one slice per match channel,
// and serves a word-addressed write port with a combinational read path.
// Assumes: CNT_W >= 3*N_CH, and N_CH <= 4 so the address map fits 4 bits.
module match_timer #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned N_CH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic [N_CH-1:0]  match_out,
    output logic             irq
);
    import mtmr_pkg::*;

    localparam int unsigned MACT_W = 3 * N_CH;
    localparam int unsigned ACTF_W = 2 * N_CH;
    localparam int unsigned PINC_W = N_CH + ACTF_W;
    localparam logic [ADDR_W-1:0] A_PINC = ADDR_W'(A_MR0 + N_CH);

    logic [1:0]        ctl_q;
    logic [CNT_W-1:0]  tc_q;
    logic [CNT_W-1:0]  plim_q;
    logic [CNT_W-1:0]  pc_v;
    logic [MACT_W-1:0] mact_q;
    logic [ACTF_W-1:0] act_q;
    logic [N_CH-1:0]   flags_q;
    logic [N_CH-1:0]   hit_v, ie_v, rs_v, sp_v;
    logic [CNT_W-1:0]  mr_v [N_CH];
    logic              tick;
    logic              ctl_we, tc_we, plim_we, pc_we, mact_we, flag_we, pinc_we;
    logic              run, hold, any_rs, any_sp;
    logic [N_CH-1:0]   flag_set;

    // Write strobes decoded from the address.
    always_comb begin
        ctl_we  = reg_we && (reg_addr == A_CTRL);
        tc_we   = reg_we && (reg_addr == A_COUNT);
        plim_we = reg_we && (reg_addr == A_PLIM);
        pc_we   = reg_we && (reg_addr == A_PCNT);
        mact_we = reg_we && (reg_addr == A_MACT);
        flag_we = reg_we && (reg_addr == A_FLAGS);
        pinc_we = reg_we && (reg_addr == A_PINC);
    end

    // Run and hold conditions from the control bits.
    always_comb begin
        hold = ctl_q[1];
        run  = ctl_q[0] && !ctl_q[1];
    end

    mtmr_prescaler #(.W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (hold),
        .limit (plim_q),
        .pc_we (pc_we),
        .wdata (reg_wdata),
        .pc    (pc_v),
        .tick  (tick)
    );

    // One slice per channel, plus its three action bits.
    for (genvar n = 0; n < N_CH; n++) begin : g_ch
        assign ie_v[n] = mact_q[3*n];
        assign rs_v[n] = mact_q[3*n+1];
        assign sp_v[n] = mact_q[3*n+2];

        mtmr_match_chan #(.W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .tc      (tc_q),
            .mr_we   (reg_we && (reg_addr == ADDR_W'(A_MR0 + n))),
            .wdata   (reg_wdata),
            .act     (ext_act_e'(act_q[2*n +: 2])),
            .st_we   (pinc_we),
            .st_wbit (reg_wdata[n]),
            .hit     (hit_v[n]),
            .mr      (mr_v[n]),
            .pin     (match_out[n])
        );
    end

    // Combined match effects.
    always_comb begin
        any_rs   = |(hit_v & rs_v);
        any_sp   = |(hit_v & sp_v);
        flag_set = hit_v & ie_v;
    end

    // Control register: a software write wins, and a stop match clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= 2'b00;
        else if (ctl_we) ctl_q <= reg_wdata[1:0];
        else if (any_sp) ctl_q[0] <= 1'b0;
    end

    // Main counter: hold, load, reset match, stop match or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      tc_q <= '0;
        else if (hold)   tc_q <= '0;
        else if (tc_we)  tc_q <= reg_wdata;
        else if (tick) begin
            if (any_rs)       tc_q <= '0;
            else if (!any_sp) tc_q <= tc_q + 1'b1;
        end
    end

    // Prescale limit, action bits and pin action fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plim_q <= '0;
            mact_q <= '0;
            act_q  <= '0;
        end else begin
            if (plim_we) plim_q <= reg_wdata;
            if (mact_we) mact_q <= reg_wdata[MACT_W-1:0];
            if (pinc_we) act_q  <= reg_wdata[PINC_W-1:N_CH];
        end
    end

    // Interrupt flags: write-one-to-clear, with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~(flag_we ? reg_wdata[N_CH-1:0] : '0)) | flag_set;
    end

    always_comb irq = |flags_q;

    // Read mux over the address map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_FLAGS: reg_rdata = CNT_W'(flags_q);
            A_CTRL:  reg_rdata = CNT_W'(ctl_q);
            A_COUNT: reg_rdata = tc_q;
            A_PLIM:  reg_rdata = plim_q;
            A_PCNT:  reg_rdata = pc_v;
            A_MACT:  reg_rdata = CNT_W'(mact_q);
            A_PINC:  reg_rdata = CNT_W'({act_q, match_out});
            default: begin
                for (int n = 0; n < N_CH; n++) begin
                    if (reg_addr == ADDR_W'(A_MR0 + n)) reg_rdata = mr_v[n];
                end
            end
        endcase
    end

    // R2: the hold bit forces the counter to zero
    assert_tc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (tc_q == '0));

    // R2: a disabled counter keeps its value
    assert_tc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q[0] && !ctl_q[1] && !tc_we) |=> $stable(tc_q));

    // R3: a reset match returns the counter to zero
    assert_tc_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rs && !tc_we) |=> (tc_q == '0));

    // R4: a stop match clears the enable bit
    assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sp && !ctl_we) |=> !ctl_q[0]);

    // R5: an enabled match raises its flag even against a clear
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

    // R5: a written one clears its flag when no match sets it
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && flag_set == '0) |=> ((flags_q & $past(reg_wdata[N_CH-1:0])) == '0));

endmodule

// File: tb/match_timer_test.sv
// Self-checking bench for match_timer: sweeps prescale limits and elapsed
// clocks, every pin action from both levels, and the match corner cases.
module match_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    localparam logic [3:0] FLG = 4'd0, CTL = 4'd1, CNT = 4'd2, PLM = 4'd3,
                           PCN = 4'd4, MAC = 4'd5, MR0 = 4'd6, PIN = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  match_out;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] v;

    match_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .match_out (match_out),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Write one register; the write lands on the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Hold counters, clear state, program limit and actions.
    task automatic setup(input logic [31:0] lim, input logic [31:0] mact);
        wr(CTL, 32'd2);
        wr(PLM, lim);
        wr(MAC, mact);
        wr(PIN, 32'd0);
        wr(FLG, 32'hF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state of every register and output
        for (int a = 0; a <= 10; a++) begin
            rd(4'(a), v);
            chk("R8 reset read", v, 32'd0);
        end
        chk("R8 pins", {28'd0, match_out}, 32'd0);
        chk("R8 irq", {31'd0, irq}, 32'd0);

        // R1: sweep limits and elapsed clocks
        for (int lim = 0; lim < 4; lim++) begin
            for (int n = 0; n < 10; n++) begin
                setup(32'(lim), 32'd0);
                wr(CTL, 32'd1);
                repeat (n) @(posedge clk);
                rd(CNT, v); chk("R1 count", v, 32'(n / (lim + 1)));
                rd(PCN, v); chk("R1 prescale", v, 32'(n % (lim + 1)));
            end
        end

        // R2: hold bit keeps both counters at zero while enabled
        setup(32'd0, 32'd0);
        wr(CTL, 32'd3);
        repeat (5) @(posedge clk);
        rd(CNT, v); chk("R2 hold count", v, 32'd0);
        rd(PCN, v); chk("R2 hold prescale", v, 32'd0);
        wr(CTL, 32'hFFFF_FFFC);
        rd(CTL, v); chk("R2 control width", v, 32'd0);

        // R7 and R2: counter load while disabled, then resume
        wr(CNT, 32'd77);
        rd(CNT, v); chk("R7 count load", v, 32'd77);
        repeat (3) @(posedge clk);
        rd(CNT, v); chk("R2 disabled holds", v, 32'd77);
        wr(PLM, 32'd3);
        wr(PCN, 32'd2);
        rd(PCN, v); chk("R7 prescale load", v, 32'd2);
        wr(CTL, 32'd1);
        @(posedge clk);
        rd(CNT, v); chk("R7 before tick", v, 32'd77);
        @(posedge clk);
        rd(CNT, v); chk("R7 after tick", v, 32'd78);

        // R3: reset on match of channel 0, period compare+1
        for (int n = 0; n < 13; n++) begin
            setup(32'd0, 32'd2);
            wr(MR0, 32'd4);
            wr(CTL, 32'd1);
            repeat (n) @(posedge clk);
            rd(CNT, v); chk("R3 period", v, 32'(n % 5));
            chk("R5 no flag when disabled", {31'd0, irq}, 32'd0);
        end

        // R5: flag sets on the match tick, a written zero keeps it
        setup(32'd0, 32'd3);
        wr(MR0, 32'd4);
        wr(CTL, 32'd1);
        repeat (4) @(posedge clk);
        rd(FLG, v); chk("R5 before match", v, 32'd0);
        @(posedge clk);
        rd(FLG, v); chk("R5 flag set", v, 32'd1);
        chk("R5 irq", {31'd0, irq}, 32'd1);
        wr(FLG, 32'd0);
        rd(FLG, v); chk("R5 zero write keeps", v, 32'd1);

        // R5: set beats clear, then a clear on its own works
        setup(32'd0, (32'd1 << 9) | (32'd1 << 10));
        wr(MR0 + 4'd3, 32'd3);
        wr(CTL, 32'd1);
        repeat (3) @(posedge clk);
        wr(FLG, 32'd8);
        rd(FLG, v); chk("R5 set wins", v, 32'd8);
        wr(FLG, 32'd8);
        rd(FLG, v); chk("R5 clear", v, 32'd0);
        chk("R5 irq low", {31'd0, irq}, 32'd0);

        // R4: stop on match of channel 1
        setup(32'd1, 32'd1 << 5);
        wr(MR0 + 4'd1, 32'd3);
        wr(CTL, 32'd1);
        repeat (7) @(posedge clk);
        rd(CTL, v); chk("R4 still running", v, 32'd1);
        @(posedge clk);
        rd(CTL, v); chk("R4 enable cleared", v, 32'd0);
        repeat (12) @(posedge clk);
        rd(CNT, v); chk("R4 rests at compare", v, 32'd3);
        rd(PCN, v); chk("R4 prescale rests", v, 32'd0);

        // R4 with R3: stop and reset together rest at zero
        setup(32'd1, (32'd1 << 4) | (32'd1 << 5));
        wr(MR0 + 4'd1, 32'd3);
        wr(CTL, 32'd1);
        repeat (20) @(posedge clk);
        rd(CNT, v); chk("R4 rest at zero", v, 32'd0);
        rd(CTL, v); chk("R4 stopped", v, 32'd0);

        // R6: every action code from both starting levels on channel 2
        for (int s = 0; s < 2; s++) begin
            for (int act = 0; act < 4; act++) begin
                logic expv;
                setup(32'd0, 32'd0);
                wr(MR0 + 4'd2, 32'd2);
                wr(PIN, (32'(act) << 8) | (32'(s) << 2));
                rd(PIN, v); chk("R6 readback", v, (32'(act) << 8) | (32'(s) << 2));
                wr(CTL, 32'd1);
                repeat (2) @(posedge clk);
                #1 chk("R6 before match", {31'd0, match_out[2]}, 32'(s));
                @(posedge clk);
                case (act)
                    0: expv = 1'(s);
                    1: expv = 1'b0;
                    2: expv = 1'b1;
                    default: expv = ~1'(s);
                endcase
                #1 chk("R6 action", {31'd0, match_out[2]}, {31'd0, expv});
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule